// File: doc/BRIEF.md
# Byte-Wide Write-Once Memory Mode Controller

This block models the control side of a byte-wide memory whose cells start at all ones and can only be cleared by programming. A host drives active-low chip-select, output-gate and program-strobe pins, a flag for the raised program supply, a flag for a raised level on address bit 9, the address bus and a data byte. The block works out the operating mode from these pins, returns stored bytes, AND-merges new data into a word on a program strobe, and returns a fixed two-byte identifier in a hidden identification mode. It drives a data byte and an output-enable that controls an external tristate driver.

Everything flows through plain pins that are sampled on the clock, so there is no valid/ready handshake and no back-pressure. The read path is combinational from the pins and the stored array. A write commits on the clock edge that first sees the strobe high again. The stored depth is a parameter, so the array can be kept small for simulation. Address bits above the stored depth are ignored. A synchronous erase input, meant for test, restores the all-ones state.

Top module: `otp_mode_ctrl`

## Requirements
- R1: While `sel_n` is 1, `dq_oe` is 0 and `dq_out` is 0x00, whatever level `gate_n` has.
- R2: With `sel_n`=0, `gate_n`=0, `strobe_n`=1, `vpp_hi`=0 and `a9_hv`=0, `dq_oe` is 1 and `dq_out` equals the stored byte at `addr[IDX_W-1:0]` in the same cycle. Higher address bits are ignored.
- R3: With `sel_n`=0 and `gate_n`=1, `dq_oe` is 0 and `dq_out` is 0x00.
- R4: After reset, and in the cycle after `wipe` has been sampled 1, every word reads 0xFF.
- R5: With `vpp_hi`=1 and `sel_n`=0, a strobe held low for at least one sampled clock and then seen high stores old AND `din` at that clock edge. The new value can be read in the following cycle.
- R6: Programming never turns a 0 bit back to 1. Writing 0xFF over a byte leaves it unchanged.
- R7: If `sel_n` rises or `vpp_hi` falls at any sampled clock while the strobe is low, no write occurs when the strobe rises.
- R8: A strobe pulse with `sel_n`=1 and `vpp_hi`=1 (inhibit), or with `vpp_hi`=0, leaves the array unchanged.
- R9: With `vpp_hi`=1, `sel_n`=0, `gate_n`=0 and `strobe_n`=1 (verify), the stored byte is output. While the strobe is low under `vpp_hi`=1, `dq_oe` is 0.
- R10: With `a9_hv`=1, `vpp_hi`=0 and `sel_n`=`gate_n`=0, the output is 0x20 when `addr[0]`=0 and 0x05 when `addr[0]`=1. All other address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; fills the array with ones |
| sel_n | input | 1 | Chip select, active low |
| gate_n | input | 1 | Output gate, active low |
| strobe_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Program supply raised |
| a9_hv | input | 1 | Raised level on address bit 9 |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Byte to program |
| wipe | input | 1 | Synchronous erase to all ones |
| dq_out | output | 8 | Data byte; 0x00 when not driven |
| dq_oe | output | 1 | Tristate enable for dq_out |

## Verification
The assertions check, on every cycle, the output gating rules for standby and a closed gate, the identifier codes, zero data whenever the outputs are off, and that a word held under a stable read address never gains a 1 bit without an erase. Only the bench's scenarios can show that a complete strobe writes the AND-merged byte, that aborted, inhibited or unpowered strobes leave the array untouched, that verify returns what was written, and that erase and address aliasing behave as required.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_OUTOFF,
    MD_READ,
    MD_PROG,
    MD_VERIFY,
    MD_IDENT
  } otp_mode_e;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h05;
  localparam logic [7:0] BLANK    = 8'hFF;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      sel_n,
  input  logic      gate_n,
  input  logic      strobe_n,
  input  logic      vpp_hi,
  input  logic      a9_hv,
  output otp_mode_e mode,
  output logic      drive
);
  always_comb begin
    if (sel_n)
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (vpp_hi)
      mode = !strobe_n ? MD_PROG : (!gate_n ? MD_VERIFY : MD_OUTOFF);
    else if (gate_n)
      mode = MD_OUTOFF;
    else if (a9_hv)
      mode = MD_IDENT;
    else
      mode = MD_READ;
  end

  assign drive = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
endmodule

// File: rtl/otp_strobe_track.sv
module otp_strobe_track (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic prog_ok,
  output logic commit
);
  logic strobe_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      armed    <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      if (strobe_n)
        armed <= 1'b0;
      else if (strobe_q)
        armed <= prog_ok;
      else
        armed <= armed & prog_ok;
    end
  end

  assign commit = strobe_n & ~strobe_q & armed & prog_ok;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
    end else if (wr) begin
      cells[idx] <= cells[idx] & wdata;
    end
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              gate_n,
  input  logic              strobe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              wipe,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  otp_mode_e  mode;
  logic       drive;
  logic       commit;
  logic [7:0] cell_byte;
  logic [IDX_W-1:0] idx;

  assign idx = addr[IDX_W-1:0];

  otp_mode_decode u_dec (
    .sel_n    (sel_n),
    .gate_n   (gate_n),
    .strobe_n (strobe_n),
    .vpp_hi   (vpp_hi),
    .a9_hv    (a9_hv),
    .mode     (mode),
    .drive    (drive)
  );

  otp_strobe_track u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .prog_ok  (vpp_hi & ~sel_n),
    .commit   (commit)
  );

  otp_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .wipe  (wipe),
    .wr    (commit),
    .idx   (idx),
    .wdata (din),
    .rdata (cell_byte)
  );

  always_comb begin
    if (!drive)
      dq_out = 8'h00;
    else if (mode == MD_IDENT)
      dq_out = addr[0] ? ID_PART : ID_MAKER;
    else
      dq_out = cell_byte;
  end

  assign dq_oe = drive;
endmodule

// File: rtl/otp_mode_ctrl_sva.sv
module otp_mode_ctrl_sva #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              gate_n,
  input logic              strobe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic              wipe,
  input logic [7:0]        dq_out,
  input logic              dq_oe
);
  logic plain_rd;
  assign plain_rd = !sel_n && !gate_n && strobe_n && !a9_hv;

  a_r1_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!dq_oe && dq_out == 8'h00));

  a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && gate_n) |-> !dq_oe);

  a_r9_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !strobe_n) |-> !dq_oe);

  a_r10_ident_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !gate_n && !vpp_hi && a9_hv) |->
      (dq_oe && dq_out == (addr[0] ? 8'h05 : 8'h20)));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 8'h00);

  a_r6_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_rd && $past(plain_rd) && $past(rst_n) && !$past(wipe) &&
     addr == $past(addr)) |-> ((dq_out & ~$past(dq_out)) == 8'h00));
endmodule

bind otp_mode_ctrl otp_mode_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .gate_n   (gate_n),
  .strobe_n (strobe_n),
  .vpp_hi   (vpp_hi),
  .a9_hv    (a9_hv),
  .addr     (addr),
  .wipe     (wipe),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/otp_mode_ctrl_test.sv
module otp_mode_ctrl_test;
  localparam int ADDR_W = 17;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  logic rst_n, sel_n, gate_n, strobe_n, vpp_hi, a9_hv, wipe;
  logic [ADDR_W-1:0] addr;
  logic [7:0] din, dq_out;
  logic dq_oe;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  otp_mode_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n),
    .strobe_n(strobe_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr),
    .din(din), .wipe(wipe), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1; gate_n = 1; strobe_n = 1; vpp_hi = 0; a9_hv = 0; wipe = 0;
  endtask

  // Returns {dq_oe, dq_out} of a plain read at address a.
  task automatic rd(input logic [ADDR_W-1:0] a, output logic [8:0] v);
    idle();
    sel_n = 0; gate_n = 0; addr = a;
    #1;
    v = {dq_oe, dq_out};
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    idle();
    vpp_hi = 1; sel_n = 0; addr = a; din = d;
    strobe_n = 0; step();
    strobe_n = 1; step();
    idle();
  endtask

  task automatic t_reset();
    logic [8:0] v;
    rst_n = 0; idle(); addr = '0; din = '0;
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 idle after reset", {dq_oe, dq_out}, 9'h000);
    rd(17'd0, v);   chk("R4 reset blank lo", v, 9'h1FF);
    rd(17'd255, v); chk("R4 reset blank hi", v, 9'h1FF);
  endtask

  task automatic t_standby();
    idle(); sel_n = 1; gate_n = 0; #1;
    chk("R1 standby gate low", {dq_oe, dq_out}, 9'h000);
    sel_n = 0; gate_n = 1; #1;
    chk("R3 gate closed", {dq_oe, dq_out}, 9'h000);
    idle();
  endtask

  task automatic t_program();
    logic [8:0] v;
    prog(17'd5, 8'hA5);
    rd(17'd5, v); chk("R5 program A5", v, 9'h1A5);
    prog(17'd5, 8'h3C);
    rd(17'd5, v); chk("R5 AND merge", v, 9'h124);
    prog(17'd5, 8'hFF);
    rd(17'd5, v); chk("R6 ones keep zeros", v, 9'h124);
    rd(17'd4, v); chk("R5 neighbour untouched", v, 9'h1FF);
    rd(17'h10105, v); chk("R2 upper bits alias", v, 9'h124);
  endtask

  task automatic t_abort();
    logic [8:0] v;
    idle(); vpp_hi = 1; sel_n = 0; addr = 17'd9; din = 8'h00;
    strobe_n = 0; step();
    sel_n = 1; step();
    sel_n = 0; step();
    strobe_n = 1; step();
    rd(17'd9, v); chk("R7 select abort", v, 9'h1FF);
    idle(); vpp_hi = 1; sel_n = 0; addr = 17'd9; din = 8'h00;
    strobe_n = 0; step();
    vpp_hi = 0; step();
    vpp_hi = 1; step();
    strobe_n = 1; step();
    rd(17'd9, v); chk("R7 supply abort", v, 9'h1FF);
  endtask

  task automatic t_inhibit();
    logic [8:0] v;
    idle(); vpp_hi = 1; sel_n = 1; addr = 17'd12; din = 8'h00;
    strobe_n = 0; step(); strobe_n = 1; step();
    rd(17'd12, v); chk("R8 inhibit no write", v, 9'h1FF);
    idle(); vpp_hi = 0; sel_n = 0; addr = 17'd12; din = 8'h00;
    strobe_n = 0; step(); strobe_n = 1; step();
    rd(17'd12, v); chk("R8 no supply no write", v, 9'h1FF);
  endtask

  task automatic t_verify();
    idle(); vpp_hi = 1; sel_n = 0; gate_n = 0; addr = 17'd5; #1;
    chk("R9 verify reads", {dq_oe, dq_out}, 9'h124);
    strobe_n = 0; din = 8'hFF; #1;
    chk("R9 off during strobe", {dq_oe, dq_out}, 9'h000);
    step(); strobe_n = 1; step();
    idle();
  endtask

  task automatic t_ident();
    idle(); sel_n = 0; gate_n = 0; a9_hv = 1; addr = 17'h1F2E4; #1;
    chk("R10 maker code", {dq_oe, dq_out}, 9'h120);
    addr = 17'h0A3B1; #1;
    chk("R10 part code", {dq_oe, dq_out}, 9'h105);
    idle();
  endtask

  task automatic t_wipe();
    logic [8:0] v;
    prog(17'd200, 8'h00);
    rd(17'd200, v); chk("R5 program zero", v, 9'h100);
    idle(); wipe = 1; step(); wipe = 0;
    rd(17'd200, v); chk("R4 wipe restores", v, 9'h1FF);
    rd(17'd5, v);   chk("R4 wipe other word", v, 9'h1FF);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_program();
    t_abort();
    t_inhibit();
    t_verify();
    t_ident();
    t_wipe();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule